// File: doc/BRIEF.md
# DMA I/O Page Translation Lookup

This block turns a device DMA bus address into a physical address by looking it up in a table of translation entries, one entry per I/O page. The page size is a power of two chosen at run time through a shift input. Each stored entry holds both the physical page address and a two-bit access code in its two lowest bits. A lookup returns the page-aligned bus address, the translated physical page, the in-page offset mask and the access code. It also raises a fault flag when the requested direction is not allowed.

A separate command engine programs the table through a one-entry-per-cycle write port. A bypass flag grants full access to every address without consulting the table. A synchronous reset clears the bypass flag and then sweeps zero into every table entry. Because an all-zero entry means "no access", a freshly reset table blocks every DMA access.

The sequencer has three states. `ST_CLEAR` sweeps the table after reset and holds `req_ready` low. `ST_IDLE` waits for a request. `ST_RESP` presents a result for one cycle. The transitions are:
- reset leads to `ST_CLEAR`;
- `ST_CLEAR` goes to `ST_IDLE` after the last entry is written;
- `ST_IDLE` goes to `ST_RESP` on a handshake;
- `ST_RESP` stays in `ST_RESP` on another handshake and otherwise returns to `ST_IDLE`.

Top module: `dma_xlate_unit`

## Requirements
- R1: After `rst` is released, `req_ready` stays low for exactly DEPTH clock cycles while the table is cleared, and `rsp_valid` stays low. During that time the table write port is ignored. Reset also clears the bypass flag.
- R2: After reset, every in-range lookup returns access code 0 and `rsp_fault` = 1, even if entries or bypass were set before reset.
- R3: `rsp_valid` is high in the cycle after a `req_valid && req_ready` handshake, and only then. Back-to-back handshakes give back-to-back results.
- R4: The table index is the bus address shifted right by `cfg_page_shift`. For an index below DEPTH, `rsp_perm` equals bits [1:0] of the entry. `rsp_phys` equals the entry with its low `cfg_page_shift` bits cleared.
- R5: For an in-range lookup, `rsp_page` is the address with its low `cfg_page_shift` bits cleared, and `rsp_mask` has exactly those low bits set.
- R6: An index equal to or greater than DEPTH, with bypass off, returns access code 0, `rsp_phys` = 0, `rsp_page` = 0, an all-ones `rsp_mask` and `rsp_fault` = 1.
- R7: With bypass on, the result is access code 3, `rsp_phys` equal to the request address (zero-extended), `rsp_page` = 0, an all-ones `rsp_mask` and no fault, whatever the table holds or the index is.
- R8: Access code encoding: 0 none, 1 read only, 2 write only, 3 read and write. A read (`req_write` = 0) faults unless bit 0 of the code is set. A write (`req_write` = 1) faults unless bit 1 is set.
- R9: A table write to the same index in the same cycle as a lookup handshake is not seen by that lookup. It is seen by the next one.
- R10: Table writes presented while `req_ready` is low (table clearing) have no effect. Every entry still reads as code 0 afterwards.
- R11: `cfg_page_shift` and the bypass flag are sampled at the handshake. A change after the handshake does not alter the result being presented.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_bypass_we | input | 1 | Load the bypass flag |
| cfg_bypass_val | input | 1 | New bypass flag value |
| cfg_page_shift | input | SHIFT_W | log2 of the I/O page size |
| tw_en | input | 1 | Table write strobe |
| tw_idx | input | IDX_W | Table entry index to write |
| tw_data | input | ENTRY_W | Entry value (physical page plus access code) |
| req_valid | input | 1 | Lookup request valid |
| req_ready | output | 1 | Lookup request accepted (low while clearing) |
| req_addr | input | ADDR_W | Device bus address |
| req_write | input | 1 | 1 = write access, 0 = read access |
| rsp_valid | output | 1 | Result valid |
| rsp_page | output | ADDR_W | Page-aligned bus address |
| rsp_phys | output | ENTRY_W | Translated physical address |
| rsp_mask | output | ADDR_W | In-page offset mask |
| rsp_perm | output | 2 | Access code granted |
| rsp_fault | output | 1 | Requested direction not permitted |

## Verification
The bench builds the block with a 16-bit bus address, 32-bit entries and an eight-entry table. This keeps the whole table, and one index past its end, reachable at page shifts of 2, 5 and 12. Every index is looked up in both directions at each shift, so all four access codes meet both directions. The small depth also makes the post-reset clear sweep short enough to count cycle by cycle. It leaves room to probe same-cycle write/lookup collisions, writes during clearing, and a shift change right after a handshake.

// File: rtl/dxl_pkg.sv
package dxl_pkg;

    typedef enum logic [1:0] {
        PERM_NONE = 2'd0,
        PERM_RD   = 2'd1,
        PERM_WR   = 2'd2,
        PERM_RW   = 2'd3
    } dxl_perm_e;

    typedef enum logic [1:0] {
        ST_CLEAR = 2'd0,
        ST_IDLE  = 2'd1,
        ST_RESP  = 2'd2
    } dxl_state_e;

    function automatic logic perm_denies(input logic [1:0] perm, input logic is_write);
        return is_write ? ~perm[1] : ~perm[0];
    endfunction

endpackage

// File: rtl/dxl_entry_ram.sv
module dxl_entry_ram #(
    parameter int DEPTH = 16,
    parameter int WIDTH = 64,
    parameter int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             we,
    input  logic [IDX_W-1:0] waddr,
    input  logic [WIDTH-1:0] wdata,
    input  logic             re,
    input  logic [IDX_W-1:0] raddr,
    output logic [WIDTH-1:0] rdata
);

    logic [WIDTH-1:0] mem [DEPTH];

    // Read returns the old content on a same-address collision
    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
        if (re) begin
            rdata <= mem[raddr];
        end
    end

endmodule

// File: rtl/dxl_seq_ctrl.sv
module dxl_seq_ctrl
    import dxl_pkg::*;
#(
    parameter int DEPTH   = 16,
    parameter int ENTRY_W = 64,
    parameter int IDX_W   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               req_valid,
    input  logic               tw_en,
    input  logic [IDX_W-1:0]   tw_idx,
    input  logic [ENTRY_W-1:0] tw_data,
    output logic               req_ready,
    output logic               rsp_valid,
    output logic               ram_we,
    output logic [IDX_W-1:0]   ram_waddr,
    output logic [ENTRY_W-1:0] ram_wdata
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DEPTH - 1);

    dxl_state_e       state_q, state_d;
    logic [IDX_W-1:0] clr_cnt_q;
    logic             hs;

    assign hs = req_valid && req_ready;

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ST_CLEAR;
            clr_cnt_q <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_CLEAR) begin
                clr_cnt_q <= clr_cnt_q + 1'b1;
            end
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_CLEAR: if (clr_cnt_q == LAST_IDX) state_d = ST_IDLE;
            ST_IDLE:  if (hs) state_d = ST_RESP;
            ST_RESP:  state_d = hs ? ST_RESP : ST_IDLE;
            default:  state_d = ST_CLEAR;
        endcase
    end

    // Outputs
    always_comb begin
        req_ready = 1'b0;
        rsp_valid = 1'b0;
        ram_we    = 1'b0;
        ram_waddr = tw_idx;
        ram_wdata = tw_data;
        unique case (state_q)
            ST_CLEAR: begin
                ram_we    = 1'b1;
                ram_waddr = clr_cnt_q;
                ram_wdata = '0;
            end
            ST_IDLE: begin
                req_ready = 1'b1;
                ram_we    = tw_en && (tw_idx <= LAST_IDX);
            end
            ST_RESP: begin
                req_ready = 1'b1;
                rsp_valid = 1'b1;
                ram_we    = tw_en && (tw_idx <= LAST_IDX);
            end
            default: ;
        endcase
    end

    AST_RSP_FOLLOWS_HS: assert property (@(posedge clk) disable iff (rst)
        hs |=> rsp_valid); // R3
    AST_RSP_NEEDS_HS: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> $past(hs)); // R3
    AST_CLEAR_LENGTH: assert property (@(posedge clk) disable iff (rst)
        $rose(req_ready) |-> ($past(clr_cnt_q) == LAST_IDX)); // R1

endmodule

// File: rtl/dxl_resp_build.sv
module dxl_resp_build
    import dxl_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int ENTRY_W = 64,
    parameter int SHIFT_W = $clog2(ADDR_W)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               valid,
    input  logic [ADDR_W-1:0]  addr_q,
    input  logic               write_q,
    input  logic [SHIFT_W-1:0] shift_q,
    input  logic               bypass_q,
    input  logic               in_range_q,
    input  logic [ENTRY_W-1:0] entry,
    output logic [ADDR_W-1:0]  page,
    output logic [ENTRY_W-1:0] phys,
    output logic [ADDR_W-1:0]  mask,
    output logic [1:0]         perm,
    output logic               fault
);

    logic [ADDR_W-1:0]  bus_pmask;
    logic [ENTRY_W-1:0] ent_pmask;

    assign bus_pmask = {ADDR_W{1'b1}} << shift_q;
    assign ent_pmask = {ENTRY_W{1'b1}} << shift_q;

    always_comb begin
        page = '0;
        phys = '0;
        mask = '1;
        perm = PERM_NONE;
        if (bypass_q) begin
            phys = ENTRY_W'(addr_q);
            perm = PERM_RW;
        end else if (in_range_q) begin
            page = addr_q & bus_pmask;
            phys = entry & ent_pmask;
            mask = ~bus_pmask;
            perm = entry[1:0];
        end
        fault = perm_denies(perm, write_q);
    end

    AST_BYPASS_FULL: assert property (@(posedge clk) disable iff (rst)
        (valid && bypass_q) |-> (perm == PERM_RW && !fault)); // R7
    AST_NONE_FAULTS: assert property (@(posedge clk) disable iff (rst)
        (valid && perm == PERM_NONE) |-> fault); // R8
    AST_OOR_BLOCKED: assert property (@(posedge clk) disable iff (rst)
        (valid && !bypass_q && !in_range_q) |-> (perm == PERM_NONE && mask == '1 && phys == '0)); // R6

endmodule

// File: rtl/dma_xlate_unit.sv
module dma_xlate_unit
    import dxl_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int ENTRY_W = 64,
    parameter int DEPTH   = 16,
    parameter int SHIFT_W = $clog2(ADDR_W),
    parameter int IDX_W   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cfg_bypass_we,
    input  logic               cfg_bypass_val,
    input  logic [SHIFT_W-1:0] cfg_page_shift,
    input  logic               tw_en,
    input  logic [IDX_W-1:0]   tw_idx,
    input  logic [ENTRY_W-1:0] tw_data,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic [ADDR_W-1:0]  req_addr,
    input  logic               req_write,
    output logic               rsp_valid,
    output logic [ADDR_W-1:0]  rsp_page,
    output logic [ENTRY_W-1:0] rsp_phys,
    output logic [ADDR_W-1:0]  rsp_mask,
    output logic [1:0]         rsp_perm,
    output logic               rsp_fault
);

    localparam logic [ADDR_W-1:0] DEPTH_A = ADDR_W'(DEPTH);

    logic               bypass_flag;
    logic               hs;
    logic [ADDR_W-1:0]  idx_full;
    logic               ram_we;
    logic [IDX_W-1:0]   ram_waddr;
    logic [ENTRY_W-1:0] ram_wdata;
    logic [ENTRY_W-1:0] ram_rdata;
    logic [ADDR_W-1:0]  addr_q;
    logic               write_q;
    logic [SHIFT_W-1:0] shift_q;
    logic               bypass_q;
    logic               in_range_q;

    assign hs       = req_valid && req_ready;
    assign idx_full = req_addr >> cfg_page_shift;

    always_ff @(posedge clk) begin
        if (rst) begin
            bypass_flag <= 1'b0;
        end else if (cfg_bypass_we) begin
            bypass_flag <= cfg_bypass_val;
        end
    end

    // Request capture at the handshake
    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q     <= '0;
            write_q    <= 1'b0;
            shift_q    <= '0;
            bypass_q   <= 1'b0;
            in_range_q <= 1'b0;
        end else if (hs) begin
            addr_q     <= req_addr;
            write_q    <= req_write;
            shift_q    <= cfg_page_shift;
            bypass_q   <= bypass_flag;
            in_range_q <= idx_full < DEPTH_A;
        end
    end

    dxl_seq_ctrl #(
        .DEPTH   (DEPTH),
        .ENTRY_W (ENTRY_W),
        .IDX_W   (IDX_W)
    ) u_seq (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .tw_en     (tw_en),
        .tw_idx    (tw_idx),
        .tw_data   (tw_data),
        .req_ready (req_ready),
        .rsp_valid (rsp_valid),
        .ram_we    (ram_we),
        .ram_waddr (ram_waddr),
        .ram_wdata (ram_wdata)
    );

    dxl_entry_ram #(
        .DEPTH (DEPTH),
        .WIDTH (ENTRY_W),
        .IDX_W (IDX_W)
    ) u_ram (
        .clk   (clk),
        .we    (ram_we),
        .waddr (ram_waddr),
        .wdata (ram_wdata),
        .re    (hs),
        .raddr (idx_full[IDX_W-1:0]),
        .rdata (ram_rdata)
    );

    dxl_resp_build #(
        .ADDR_W  (ADDR_W),
        .ENTRY_W (ENTRY_W),
        .SHIFT_W (SHIFT_W)
    ) u_resp (
        .clk        (clk),
        .rst        (rst),
        .valid      (rsp_valid),
        .addr_q     (addr_q),
        .write_q    (write_q),
        .shift_q    (shift_q),
        .bypass_q   (bypass_q),
        .in_range_q (in_range_q),
        .entry      (ram_rdata),
        .page       (rsp_page),
        .phys       (rsp_phys),
        .mask       (rsp_mask),
        .perm       (rsp_perm),
        .fault      (rsp_fault)
    );

    AST_CLEAR_WRITES_ZERO: assert property (@(posedge clk) disable iff (rst)
        (!req_ready && ram_we) |-> (ram_wdata == '0)); // R10
    AST_NO_RSP_CLEARING: assert property (@(posedge clk) disable iff (rst)
        !req_ready |-> !rsp_valid); // R1

endmodule

// File: tb/dma_xlate_unit_tb.sv
module dma_xlate_unit_tb;

    localparam int AW = 16;
    localparam int EW = 32;
    localparam int DP = 8;
    localparam int SW = 4;
    localparam int IW = 3;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cfg_bypass_we = 1'b0;
    logic          cfg_bypass_val = 1'b0;
    logic [SW-1:0] cfg_page_shift = 4'd2;
    logic          tw_en = 1'b0;
    logic [IW-1:0] tw_idx = '0;
    logic [EW-1:0] tw_data = '0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [AW-1:0] req_addr = '0;
    logic          req_write = 1'b0;
    logic          rsp_valid;
    logic [AW-1:0] rsp_page;
    logic [EW-1:0] rsp_phys;
    logic [AW-1:0] rsp_mask;
    logic [1:0]    rsp_perm;
    logic          rsp_fault;

    int checks = 0;
    int failures = 0;
    logic [EW-1:0] model [DP];

    always #5 clk = ~clk;

    dma_xlate_unit #(.ADDR_W(AW), .ENTRY_W(EW), .DEPTH(DP)) u_dut (
        .clk(clk), .rst(rst),
        .cfg_bypass_we(cfg_bypass_we), .cfg_bypass_val(cfg_bypass_val),
        .cfg_page_shift(cfg_page_shift),
        .tw_en(tw_en), .tw_idx(tw_idx), .tw_data(tw_data),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_write(req_write),
        .rsp_valid(rsp_valid), .rsp_page(rsp_page), .rsp_phys(rsp_phys),
        .rsp_mask(rsp_mask), .rsp_perm(rsp_perm), .rsp_fault(rsp_fault)
    );

    task automatic check(input string tag, input logic [67:0] act, input logic [67:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [67:0] expect_rsp(input logic [AW-1:0] a, input logic w,
                                               input logic byp, input int sh);
        logic [AW-1:0] pm;
        logic [EW-1:0] e;
        logic [1:0]    p;
        int            idx;
        pm  = 16'hFFFF << sh;
        idx = int'(a >> sh);
        if (byp) return {1'b1, 16'h0, 16'h0, a, 16'hFFFF, 2'd3, 1'b0};
        if (idx >= DP) return {1'b1, 16'h0, 32'h0, 16'hFFFF, 2'd0, 1'b1};
        e = model[idx];
        p = e[1:0];
        return {1'b1, a & pm, e & (32'hFFFF_FFFF << sh), ~pm, p, (w ? ~p[1] : ~p[0])};
    endfunction

    task automatic table_write(input int idx, input logic [EW-1:0] d);
        @(negedge clk);
        tw_en = 1'b1; tw_idx = IW'(idx); tw_data = d;
        @(negedge clk);
        tw_en = 1'b0;
        model[idx] = d;
    endtask

    task automatic lookup(input string tag, input logic [AW-1:0] a, input logic w,
                          input logic byp, input int sh, input int sh_after);
        @(negedge clk);
        cfg_page_shift = SW'(sh);
        req_valid = 1'b1; req_addr = a; req_write = w;
        @(negedge clk);
        req_valid = 1'b0;
        cfg_page_shift = SW'(sh_after);
        #1;
        check(tag, {rsp_valid, rsp_page, rsp_phys, rsp_mask, rsp_perm, rsp_fault},
              expect_rsp(a, w, byp, sh));
    endtask

    task automatic do_reset(input logic write_during_clear);
        @(negedge clk);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        if (write_during_clear) begin
            tw_en = 1'b1; tw_idx = 3'd2; tw_data = 32'h0000_F003;
        end
        // R1: ready low for DP cycles, then high
        for (int c = 0; c < DP; c++) begin
            #1;
            check("R1 ready low while clearing", {66'h0, req_ready, rsp_valid}, 68'h0);
            @(negedge clk);
        end
        tw_en = 1'b0;
        #1;
        check("R1 ready after clear", {67'h0, req_ready}, 68'h1);
        for (int i = 0; i < DP; i++) model[i] = '0;
    endtask

    function automatic logic [EW-1:0] pattern(input int i);
        return (32'h5A5A_0000 + 32'(i) * 32'h0101_3000) | 32'h3C | 32'(i % 4);
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int shifts [3] = '{2, 5, 12};
        logic [AW-1:0] a;
        for (int i = 0; i < DP; i++) model[i] = '0;

        do_reset(1'b0);

        // R2: cleared table blocks everything
        for (int i = 0; i < DP; i++) begin
            lookup("R2 cleared entry", AW'(i << 2), 1'b0, 1'b0, 2, 2);
        end

        for (int i = 0; i < DP; i++) table_write(i, pattern(i));

        // R4 R5 R6 R8: sweep shifts, indices, directions
        foreach (shifts[s]) begin
            for (int i = 0; i <= DP; i++) begin
                for (int w = 0; w < 2; w++) begin
                    a = AW'((i << shifts[s]) | ((5 * (i + 1) + 3) & ((1 << shifts[s]) - 1)));
                    lookup(i < DP ? "R4 R5 R8 in-range" : "R6 index at depth",
                           a, w[0], 1'b0, shifts[s], shifts[s]);
                end
            end
        end
        lookup("R6 far out of range", 16'hFFFF, 1'b0, 1'b0, 2, 2);

        // R3: back-to-back handshakes, then idle
        @(negedge clk);
        req_valid = 1'b1; req_addr = 16'h0004; req_write = 1'b0;
        @(negedge clk);
        req_addr = 16'h0008;
        #1;
        check("R3 first of pair", {rsp_valid, rsp_page, rsp_phys, rsp_mask, rsp_perm, rsp_fault},
              expect_rsp(16'h0004, 1'b0, 1'b0, 2));
        @(negedge clk);
        req_valid = 1'b0;
        #1;
        check("R3 second of pair", {rsp_valid, rsp_page, rsp_phys, rsp_mask, rsp_perm, rsp_fault},
              expect_rsp(16'h0008, 1'b0, 1'b0, 2));
        @(negedge clk);
        #1;
        check("R3 no result without handshake", {67'h0, rsp_valid}, 68'h0);

        // R9: same-cycle write and lookup of index 3
        @(negedge clk);
        tw_en = 1'b1; tw_idx = 3'd3; tw_data = 32'h1234_5002;
        req_valid = 1'b1; req_addr = 16'h000D; req_write = 1'b1;
        @(negedge clk);
        tw_en = 1'b0; req_valid = 1'b0;
        #1;
        check("R9 collision sees old entry", {rsp_valid, rsp_page, rsp_phys, rsp_mask, rsp_perm, rsp_fault},
              expect_rsp(16'h000D, 1'b1, 1'b0, 2));
        model[3] = 32'h1234_5002;
        lookup("R9 next lookup sees new entry", 16'h000D, 1'b1, 1'b0, 2, 2);

        // R11: shift change after handshake has no effect
        lookup("R11 shift sampled at handshake", 16'h0017, 1'b0, 1'b0, 2, 12);

        // R7: bypass
        @(negedge clk);
        cfg_bypass_we = 1'b1; cfg_bypass_val = 1'b1;
        @(negedge clk);
        cfg_bypass_we = 1'b0;
        model[0] = '0;
        table_write(0, 32'h0000_0000);
        lookup("R7 bypass over no-access entry", 16'h0002, 1'b1, 1'b1, 2, 2);
        lookup("R7 bypass out of range", 16'hBEEF, 1'b0, 1'b1, 2, 2);

        // R11: bypass cleared after handshake keeps bypass result
        @(negedge clk);
        req_valid = 1'b1; req_addr = 16'h0001; req_write = 1'b0;
        cfg_page_shift = 4'd2;
        @(negedge clk);
        req_valid = 1'b0;
        cfg_bypass_we = 1'b1; cfg_bypass_val = 1'b0;
        #1;
        check("R11 bypass sampled at handshake", {rsp_valid, rsp_page, rsp_phys, rsp_mask, rsp_perm, rsp_fault},
              expect_rsp(16'h0001, 1'b0, 1'b1, 2));
        @(negedge clk);
        cfg_bypass_we = 1'b0;
        lookup("R7 bypass off uses table", 16'h0001, 1'b0, 1'b0, 2, 2);

        // R1 R2 R10: set bypass and entries, reset with writes during clear
        for (int i = 0; i < DP; i++) table_write(i, pattern(i) | 32'h3);
        @(negedge clk);
        cfg_bypass_we = 1'b1; cfg_bypass_val = 1'b1;
        @(negedge clk);
        cfg_bypass_we = 1'b0;
        do_reset(1'b1);
        lookup("R10 write during clear ignored", 16'h0008, 1'b0, 1'b0, 2, 2);
        for (int i = 0; i < DP; i++) begin
            lookup("R2 R1 reset cleared entry and bypass", AW'(i << 5), 1'b1, 1'b0, 5, 5);
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule